// File: doc/BRIEF.md
# Shared Mailbox Register Bank

This block places six 16-bit mailbox registers between a host bus and a processor core. Each side has its own single-cycle synchronous port: a 3-bit register index, a read strobe, a write strobe and 16-bit write data. Read data appears on the port's registered read-data output one clock after the read strobe. Indices 0 to 5 select the mailbox words. Index 6 selects the low status word and index 7 the high status word. On the core side a separate select line picks the interrupt-enable word and ignores the index. The host strobes are assumed to be already synchronized to the core clock.

Every mailbox word carries two directional "fresh data" flags: one set by the host's write and one set by the core's write. A read from the opposite side clears each flag. These flags, a read-ready state per word and the enable word drive two interrupt requests towards the core. A write to the high status word can also request a software reset. This produces a fixed-length pulse that returns all control state to its reset values and leaves the mailbox contents untouched.

Top module: `mbox_bank`

## Requirements
- R1: Each of the six mailbox words can be written and read by both sides. A read strobe with index n (0 to 5) presents word n on that side's read-data output one clock later. Read data only changes on a read strobe.
- R2: A host write to word n sets bit n of the low status word (index 6). A core read of word n clears that bit. If a set and a clear hit the same bit in the same cycle, the set wins.
- R3: A core write to word n sets bit 8+n of the low status word. A host read of word n clears that bit. If a set and a clear hit the same bit in the same cycle, the set wins.
- R4: The high status word (index 7) has these fields: bits 5:0 are a live copy of low-status bits 13:8, bit 7 is a read/write overwrite-mode bit, and bit 6 and bits 15:8 read as 0. Writes to the low status word have no effect.
- R5: The core-side enable word has two halves. Bits 5:0 enable the host-write request of word n, and bits 13:8 enable the read-ready request of word n. The other bits read 0. Only the core can write the enable word, and only with the select line high.
- R6: irq_host_wr is the OR over n of (low-status bit n AND enable bit n). It stays high until the core reads the word.
- R7: irq_host_rd is the OR over n of (read-ready n AND enable bit 8+n). Read-ready n is 1 after any reset. A host read of word n sets it and a core write of word n clears it; when both happen in the same cycle, the core write wins.
- R8: Writing 1 to bit 6 of the high status word from either side drives soft_rst high for exactly 5 clocks. While soft_rst is high, all strobes are ignored and the status bits, enable word and overwrite bit return to their reset values. The mailbox words keep their contents through both soft and hardware reset.
- R9: If both sides write the same mailbox word in the same cycle, the host's data is stored.
- R10: A host read of index 6 or 7 returns the status captured at the previous host access (read or write). Two back-to-back host reads therefore return the current status on the second.
- R11: With host_narrow high, a host write stores its low byte with the upper byte zeroed, and a host read returns the low byte with the upper byte zero.
- R12: After hardware reset, both status words are 0 except the overwrite bit (reads 0x0080), the enable word is 0, both requests are low, soft_rst is low and both read-data outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_narrow | input | 1 | Host access uses only the low byte |
| host_idx | input | 3 | Host register index |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data, registered |
| core_rd | input | 1 | Core read strobe |
| core_wr | input | 1 | Core write strobe |
| core_mask_sel | input | 1 | Core access targets the enable word |
| core_idx | input | 3 | Core register index |
| core_wdata | input | 16 | Core write data |
| core_rdata | output | 16 | Core read data, registered |
| irq_host_wr | output | 1 | Enabled host-write request pending |
| irq_host_rd | output | 1 | Enabled read-ready request pending |
| soft_rst | output | 1 | Software reset pulse |

## Verification
A stuck or misprioritized fresh-data flag shows up in the core's status read the clock after the event. It also shows up on irq_host_wr one clock after the event, once that word's enable is set. A broken read-ready state shows up the same way on irq_host_rd. A wrong host status snapshot appears only at the host port, on the first of two back-to-back status reads, and the second read must then agree with the core's view. A miscounted soft reset is visible as a wrong pulse width. A leak of strobes during the pulse shows in the enable word, status and mailbox contents read right after soft_rst falls.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    localparam int DATA_W          = 16;
    localparam int NUM_REGS        = 6;
    localparam int IDX_W           = 3;
    localparam int HALF_W          = DATA_W / 2;
    localparam int STAT_LO_IDX     = 6;
    localparam int STAT_HI_IDX     = 7;
    localparam int OVW_BIT         = 7;
    localparam int SRST_BIT        = 6;
    localparam int SRST_CYCLES_DEF = 5;

    typedef logic [DATA_W-1:0]   word_t;
    typedef logic [NUM_REGS-1:0] regvec_t;
    typedef logic [IDX_W-1:0]    idx_t;

    // control-side view of the bank
    typedef struct packed {
        regvec_t hw;   // host wrote word n, core has not read it
        regvec_t cw;   // core wrote word n, host has not read it
        logic    ovw;  // overwrite-mode bit
    } status_t;

    function automatic status_t status_reset();
        status_t s;
        s.hw  = '0;
        s.cw  = '0;
        s.ovw = 1'b1;
        return s;
    endfunction

    // low half / high half placement shared by status-low and enable word
    function automatic word_t pack_pair(regvec_t lo, regvec_t hi);
        word_t w;
        w = '0;
        w[NUM_REGS-1:0]       = lo;
        w[HALF_W +: NUM_REGS] = hi;
        return w;
    endfunction

    function automatic word_t stat_lo_word(status_t s);
        return pack_pair(s.hw, s.cw);
    endfunction

    function automatic word_t stat_hi_word(status_t s);
        word_t w;
        w = '0;
        w[NUM_REGS-1:0] = s.cw;
        w[OVW_BIT]      = s.ovw;
        return w;
    endfunction

    function automatic word_t narrow_word(word_t v);
        word_t w;
        w = '0;
        w[HALF_W-1:0] = v[HALF_W-1:0];
        return w;
    endfunction

    function automatic regvec_t idx_onehot(idx_t idx, logic en);
        regvec_t v;
        for (int i = 0; i < NUM_REGS; i++) begin
            v[i] = en && (idx == IDX_W'(i));
        end
        return v;
    endfunction

endpackage

// File: rtl/mbox_data.sv
module mbox_data
    import mbox_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  regvec_t h_we,
    input  regvec_t c_we,
    input  word_t   h_wdata,
    input  word_t   c_wdata,
    output word_t   data_q [NUM_REGS]
);

    // mailbox words carry no reset: contents survive any reset
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (h_we[g]) begin
                data_q[g] <= h_wdata;
            end else if (c_we[g]) begin
                data_q[g] <= c_wdata;
            end
        end

        // R9: host data wins a same-cycle collision
        a_r9_host_wins: assert property (@(posedge clk) disable iff (rst)
            (h_we[g] && c_we[g]) |=> (data_q[g] == $past(h_wdata)));

        // R1: a lone core write lands
        a_r1_core_write: assert property (@(posedge clk) disable iff (rst)
            (c_we[g] && !h_we[g]) |=> (data_q[g] == $past(c_wdata)));
    end

endmodule

// File: rtl/mbox_flags.sv
module mbox_flags
    import mbox_pkg::*;
(
    input  logic    clk,
    input  logic    ctl_rst,
    input  regvec_t h_rd,
    input  regvec_t h_wr,
    input  regvec_t c_rd,
    input  regvec_t c_wr,
    output regvec_t hw_q,
    output regvec_t cw_q,
    output regvec_t rr_q
);

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_flag
        // host-written flag: set by host write, cleared by core read
        always_ff @(posedge clk) begin
            if (ctl_rst)      hw_q[g] <= 1'b0;
            else if (h_wr[g]) hw_q[g] <= 1'b1;
            else if (c_rd[g]) hw_q[g] <= 1'b0;
        end

        // core-written flag: set by core write, cleared by host read
        always_ff @(posedge clk) begin
            if (ctl_rst)      cw_q[g] <= 1'b0;
            else if (c_wr[g]) cw_q[g] <= 1'b1;
            else if (h_rd[g]) cw_q[g] <= 1'b0;
        end

        // read-ready: core write clears, host read sets, core write wins
        always_ff @(posedge clk) begin
            if (ctl_rst)      rr_q[g] <= 1'b1;
            else if (c_wr[g]) rr_q[g] <= 1'b0;
            else if (h_rd[g]) rr_q[g] <= 1'b1;
        end

        a_r2_hw_set: assert property (@(posedge clk) disable iff (ctl_rst)
            h_wr[g] |=> hw_q[g]);
        a_r2_hw_clear: assert property (@(posedge clk) disable iff (ctl_rst)
            (c_rd[g] && !h_wr[g]) |=> !hw_q[g]);
        a_r3_cw_set: assert property (@(posedge clk) disable iff (ctl_rst)
            c_wr[g] |=> cw_q[g]);
        a_r3_cw_clear: assert property (@(posedge clk) disable iff (ctl_rst)
            (h_rd[g] && !c_wr[g]) |=> !cw_q[g]);
        a_r7_rr_clear: assert property (@(posedge clk) disable iff (ctl_rst)
            c_wr[g] |=> !rr_q[g]);
    end

endmodule

// File: rtl/mbox_srst.sv
module mbox_srst #(
    parameter int LEN = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    output logic pulse
);

    localparam int CW = $clog2(LEN + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (fire && cnt_q == '0) begin
            cnt_q <= CW'(LEN);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign pulse = (cnt_q != '0);

    // checker: length of each high run
    logic [CW:0] run_q;
    always_ff @(posedge clk) begin
        if (rst)        run_q <= '0;
        else if (pulse) run_q <= run_q + 1'b1;
        else            run_q <= '0;
    end

    // R8: pulse is exactly LEN cycles
    a_r8_pulse_len: assert property (@(posedge clk) disable iff (rst)
        ($fell(pulse) && !$past(rst)) |-> (run_q == (CW+1)'(LEN)));

    a_r8_fire_starts: assert property (@(posedge clk) disable iff (rst)
        (fire && !pulse) |=> pulse);

endmodule

// File: rtl/mbox_bank.sv
module mbox_bank
    import mbox_pkg::*;
#(
    parameter int SRST_CYCLES = SRST_CYCLES_DEF
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        host_rd,
    input  logic        host_wr,
    input  logic        host_narrow,
    input  logic [2:0]  host_idx,
    input  logic [15:0] host_wdata,
    output logic [15:0] host_rdata,
    input  logic        core_rd,
    input  logic        core_wr,
    input  logic        core_mask_sel,
    input  logic [2:0]  core_idx,
    input  logic [15:0] core_wdata,
    output logic [15:0] core_rdata,
    output logic        irq_host_wr,
    output logic        irq_host_rd,
    output logic        soft_rst
);

    logic    busy;
    logic    ctl_rst;
    logic    h_go_rd, h_go_wr, c_go_rd, c_go_wr;
    regvec_t h_rd_v, h_wr_v, c_rd_v, c_wr_v;
    regvec_t hw_q, cw_q, rr_q;
    regvec_t men_wr_q, men_rd_q;
    logic    ovw_q;
    logic    h_hi_wr, c_hi_wr, srst_fire;
    word_t   h_wdata_eff;
    word_t   data_q [NUM_REGS];
    word_t   h_sel, c_sel, h_val, c_val;
    word_t   snap_lo_q, snap_hi_q;
    status_t st;

    assign ctl_rst = rst | busy;

    // strobes are dropped while the soft reset pulse runs
    assign h_go_rd = host_rd & ~busy;
    assign h_go_wr = host_wr & ~busy;
    assign c_go_rd = core_rd & ~busy & ~core_mask_sel;
    assign c_go_wr = core_wr & ~busy & ~core_mask_sel;

    assign h_rd_v = idx_onehot(host_idx, h_go_rd);
    assign h_wr_v = idx_onehot(host_idx, h_go_wr);
    assign c_rd_v = idx_onehot(core_idx, c_go_rd);
    assign c_wr_v = idx_onehot(core_idx, c_go_wr);

    assign h_wdata_eff = host_narrow ? narrow_word(host_wdata) : host_wdata;

    assign h_hi_wr   = h_go_wr && (host_idx == IDX_W'(STAT_HI_IDX));
    assign c_hi_wr   = c_go_wr && (core_idx == IDX_W'(STAT_HI_IDX));
    assign srst_fire = (h_hi_wr && host_wdata[SRST_BIT]) ||
                       (c_hi_wr && core_wdata[SRST_BIT]);

    mbox_srst #(.LEN(SRST_CYCLES)) u_srst (
        .clk   (clk),
        .rst   (rst),
        .fire  (srst_fire),
        .pulse (busy)
    );

    mbox_data u_data (
        .clk     (clk),
        .rst     (rst),
        .h_we    (h_wr_v),
        .c_we    (c_wr_v),
        .h_wdata (h_wdata_eff),
        .c_wdata (core_wdata),
        .data_q  (data_q)
    );

    mbox_flags u_flags (
        .clk     (clk),
        .ctl_rst (ctl_rst),
        .h_rd    (h_rd_v),
        .h_wr    (h_wr_v),
        .c_rd    (c_rd_v),
        .c_wr    (c_wr_v),
        .hw_q    (hw_q),
        .cw_q    (cw_q),
        .rr_q    (rr_q)
    );

    // overwrite-mode bit, host write takes precedence
    always_ff @(posedge clk) begin
        if (ctl_rst)      ovw_q <= 1'b1;
        else if (h_hi_wr) ovw_q <= host_wdata[OVW_BIT];
        else if (c_hi_wr) ovw_q <= core_wdata[OVW_BIT];
    end

    // interrupt enable word, core side only
    always_ff @(posedge clk) begin
        if (ctl_rst) begin
            men_wr_q <= '0;
            men_rd_q <= '0;
        end else if (core_wr && core_mask_sel) begin
            men_wr_q <= core_wdata[NUM_REGS-1:0];
            men_rd_q <= core_wdata[HALF_W +: NUM_REGS];
        end
    end

    assign st.hw  = hw_q;
    assign st.cw  = cw_q;
    assign st.ovw = ovw_q;

    // host status snapshot, refreshed at every host access
    always_ff @(posedge clk) begin
        if (ctl_rst) begin
            snap_lo_q <= stat_lo_word(status_reset());
            snap_hi_q <= stat_hi_word(status_reset());
        end else if (h_go_rd || h_go_wr) begin
            snap_lo_q <= stat_lo_word(st);
            snap_hi_q <= stat_hi_word(st);
        end
    end

    always_comb begin
        h_sel = '0;
        c_sel = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (host_idx == IDX_W'(i)) h_sel = data_q[i];
            if (core_idx == IDX_W'(i)) c_sel = data_q[i];
        end
    end

    always_comb begin
        if (host_idx == IDX_W'(STAT_LO_IDX))      h_val = snap_lo_q;
        else if (host_idx == IDX_W'(STAT_HI_IDX)) h_val = snap_hi_q;
        else                                      h_val = h_sel;
        if (host_narrow) h_val = narrow_word(h_val);
    end

    always_comb begin
        if (core_mask_sel)                        c_val = pack_pair(men_wr_q, men_rd_q);
        else if (core_idx == IDX_W'(STAT_LO_IDX)) c_val = stat_lo_word(st);
        else if (core_idx == IDX_W'(STAT_HI_IDX)) c_val = stat_hi_word(st);
        else                                      c_val = c_sel;
    end

    always_ff @(posedge clk) begin
        if (rst)          host_rdata <= '0;
        else if (h_go_rd) host_rdata <= h_val;
    end

    always_ff @(posedge clk) begin
        if (rst)                           core_rdata <= '0;
        else if (core_rd && !busy)         core_rdata <= c_val;
    end

    assign irq_host_wr = |(hw_q & men_wr_q);
    assign irq_host_rd = |(rr_q & men_rd_q);
    assign soft_rst    = busy;

    // R4: reserved and reset bits of the high status word read zero
    a_r4_hi_reserved: assert property (@(posedge clk) disable iff (rst)
        (core_rd && !busy && !core_mask_sel && core_idx == IDX_W'(STAT_HI_IDX))
        |=> (core_rdata[15:8] == 8'h00 && core_rdata[SRST_BIT] == 1'b0));

    // R11: narrow host reads never carry an upper byte
    a_r11_narrow_read: assert property (@(posedge clk) disable iff (rst)
        (host_rd && host_narrow && !busy) |=> (host_rdata[15:8] == 8'h00));

    // R8: control state held at reset values during the pulse
    a_r8_hold_reset: assert property (@(posedge clk) disable iff (rst)
        busy |=> (men_wr_q == '0 && men_rd_q == '0 && ovw_q && hw_q == '0));

    // R1: read data moves only on a read strobe
    a_r1_rdata_hold: assert property (@(posedge clk) disable iff (rst)
        (!core_rd && !$past(rst)) |=> $stable(core_rdata));

endmodule

// File: tb/mbox_bank_test.sv
module mbox_bank_test;

    localparam int CLK_PERIOD = 10;
    localparam int NSTEP      = 33;

    typedef struct packed {
        logic        hrd;
        logic        hwr;
        logic        hnar;
        logic [2:0]  hidx;
        logic [15:0] hwd;
        logic        crd;
        logic        cwr;
        logic        cmsk;
        logic [2:0]  cidx;
        logic [15:0] cwd;
        logic        chkh;
        logic [15:0] exph;
        logic        chkc;
        logic [15:0] expc;
        logic [1:0]  irq;   // {irq_host_rd, irq_host_wr}
        logic [3:0]  req;
    } step_t;

    localparam step_t TBL [NSTEP] = '{
        '{0,0,0,3'd0,16'h0000, 0,1,1,3'd0,16'h3F3F, 0,16'h0000, 0,16'h0000, 2'b10, 4'd5},  // R5 enable all
        '{0,0,0,3'd0,16'h0000, 1,0,1,3'd0,16'h0000, 0,16'h0000, 1,16'h3F3F, 2'b10, 4'd5},  // R5 read back
        '{0,1,0,3'd0,16'h1234, 0,0,0,3'd0,16'h0000, 0,16'h0000, 0,16'h0000, 2'b11, 4'd6},  // R6 host wr
        '{0,0,0,3'd0,16'h0000, 1,0,0,3'd6,16'h0000, 0,16'h0000, 1,16'h0001, 2'b11, 4'd2},  // R2 flag set
        '{0,0,0,3'd0,16'h0000, 1,0,0,3'd0,16'h0000, 0,16'h0000, 1,16'h1234, 2'b10, 4'd1},  // R1 core rd
        '{0,0,0,3'd0,16'h0000, 0,1,0,3'd2,16'hBEEF, 0,16'h0000, 0,16'h0000, 2'b10, 4'd3},  // R3 core wr
        '{0,0,0,3'd0,16'h0000, 1,0,0,3'd7,16'h0000, 0,16'h0000, 1,16'h0084, 2'b10, 4'd4},  // R4 mirror
        '{1,0,0,3'd6,16'h0000, 0,0,0,3'd0,16'h0000, 1,16'h0000, 0,16'h0000, 2'b10, 4'd10}, // R10 stale
        '{1,0,0,3'd6,16'h0000, 0,0,0,3'd0,16'h0000, 1,16'h0400, 0,16'h0000, 2'b10, 4'd10}, // R10 current
        '{1,0,0,3'd2,16'h0000, 0,0,0,3'd0,16'h0000, 1,16'hBEEF, 0,16'h0000, 2'b10, 4'd3},  // R3 host rd
        '{1,0,0,3'd7,16'h0000, 0,0,0,3'd0,16'h0000, 1,16'h0084, 0,16'h0000, 2'b10, 4'd10}, // R10 stale hi
        '{1,0,0,3'd7,16'h0000, 0,0,0,3'd0,16'h0000, 1,16'h0080, 0,16'h0000, 2'b10, 4'd4},  // R4 cleared
        '{0,1,1,3'd1,16'hA5C3, 0,0,0,3'd0,16'h0000, 0,16'h0000, 0,16'h0000, 2'b11, 4'd11}, // R11 narrow wr
        '{0,0,0,3'd0,16'h0000, 1,0,0,3'd1,16'h0000, 0,16'h0000, 1,16'h00C3, 2'b10, 4'd11}, // R11 stored
        '{0,0,0,3'd0,16'h0000, 0,1,0,3'd3,16'hFACE, 0,16'h0000, 0,16'h0000, 2'b10, 4'd1},  // R1 core wr
        '{1,0,1,3'd3,16'h0000, 0,0,0,3'd0,16'h0000, 1,16'h00CE, 0,16'h0000, 2'b10, 4'd11}, // R11 narrow rd
        '{0,0,0,3'd0,16'h0000, 0,1,1,3'd0,16'h0004, 0,16'h0000, 0,16'h0000, 2'b00, 4'd5},  // R5 one enable
        '{0,1,0,3'd0,16'h1111, 0,0,0,3'd0,16'h0000, 0,16'h0000, 0,16'h0000, 2'b00, 4'd6},  // R6 masked
        '{0,1,0,3'd2,16'h2222, 0,0,0,3'd0,16'h0000, 0,16'h0000, 0,16'h0000, 2'b01, 4'd6},  // R6 enabled
        '{0,0,0,3'd0,16'h0000, 1,0,0,3'd0,16'h0000, 0,16'h0000, 1,16'h1111, 2'b01, 4'd6},  // R6 other rd
        '{0,0,0,3'd0,16'h0000, 1,0,0,3'd2,16'h0000, 0,16'h0000, 1,16'h2222, 2'b00, 4'd6},  // R6 cleared
        '{0,1,0,3'd4,16'hAAAA, 0,1,0,3'd4,16'h5555, 0,16'h0000, 0,16'h0000, 2'b00, 4'd9},  // R9 collision
        '{0,0,0,3'd0,16'h0000, 1,0,0,3'd4,16'h0000, 0,16'h0000, 1,16'hAAAA, 2'b00, 4'd9},  // R9 host won
        '{1,0,0,3'd4,16'h0000, 0,0,0,3'd0,16'h0000, 1,16'hAAAA, 0,16'h0000, 2'b00, 4'd3},  // R3 host rd
        '{0,0,0,3'd0,16'h0000, 0,1,1,3'd0,16'h1000, 0,16'h0000, 0,16'h0000, 2'b10, 4'd7},  // R7 ready
        '{0,0,0,3'd0,16'h0000, 0,1,0,3'd4,16'h0404, 0,16'h0000, 0,16'h0000, 2'b00, 4'd7},  // R7 core wr
        '{1,0,0,3'd4,16'h0000, 0,0,0,3'd0,16'h0000, 1,16'h0404, 0,16'h0000, 2'b10, 4'd7},  // R7 host rd
        '{0,0,0,3'd0,16'h0000, 0,1,0,3'd7,16'h0000, 0,16'h0000, 0,16'h0000, 2'b10, 4'd4},  // R4 ovw off
        '{0,0,0,3'd0,16'h0000, 1,0,0,3'd7,16'h0000, 0,16'h0000, 1,16'h0000, 2'b10, 4'd4},  // R4 ovw read
        '{0,1,0,3'd7,16'hFFBF, 0,0,0,3'd0,16'h0000, 0,16'h0000, 0,16'h0000, 2'b10, 4'd4},  // R4 host ovw on
        '{0,0,0,3'd0,16'h0000, 1,0,0,3'd7,16'h0000, 0,16'h0000, 1,16'h0080, 2'b10, 4'd4},  // R4 ovw read
        '{0,1,0,3'd6,16'hFFFF, 1,0,0,3'd6,16'h0000, 0,16'h0000, 1,16'h0000, 2'b10, 4'd4},  // R4 lo write
        '{0,0,0,3'd0,16'h0000, 1,0,0,3'd6,16'h0000, 0,16'h0000, 1,16'h0000, 2'b10, 4'd4}   // R4 ignored
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        host_rd, host_wr, host_narrow;
    logic [2:0]  host_idx;
    logic [15:0] host_wdata, host_rdata;
    logic        core_rd, core_wr, core_mask_sel;
    logic [2:0]  core_idx;
    logic [15:0] core_wdata, core_rdata;
    logic        irq_host_wr, irq_host_rd, soft_rst;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    mbox_bank uut (
        .clk           (clk),
        .rst           (rst),
        .host_rd       (host_rd),
        .host_wr       (host_wr),
        .host_narrow   (host_narrow),
        .host_idx      (host_idx),
        .host_wdata    (host_wdata),
        .host_rdata    (host_rdata),
        .core_rd       (core_rd),
        .core_wr       (core_wr),
        .core_mask_sel (core_mask_sel),
        .core_idx      (core_idx),
        .core_wdata    (core_wdata),
        .core_rdata    (core_rdata),
        .irq_host_wr   (irq_host_wr),
        .irq_host_rd   (irq_host_rd),
        .soft_rst      (soft_rst)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic cmp(input string what, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic idle();
        host_rd = 0; host_wr = 0; host_narrow = 0; host_idx = 0; host_wdata = 0;
        core_rd = 0; core_wr = 0; core_mask_sel = 0; core_idx = 0; core_wdata = 0;
    endtask

    // one access per side, applied at a falling edge, results read at the next
    task automatic cycle(input logic hrd, input logic hwr, input logic [2:0] hidx,
                         input logic [15:0] hwd, input logic crd, input logic cwr,
                         input logic cmsk, input logic [2:0] cidx, input logic [15:0] cwd);
        host_rd = hrd; host_wr = hwr; host_idx = hidx; host_wdata = hwd;
        core_rd = crd; core_wr = cwr; core_mask_sel = cmsk; core_idx = cidx; core_wdata = cwd;
        @(negedge clk);
        idle();
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        int hi_cnt;
        idle();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R12 reset state
        cmp("R12 irq", {14'd0, irq_host_rd, irq_host_wr}, 16'h0000);
        cmp("R12 soft_rst", {15'd0, soft_rst}, 16'h0000);
        cmp("R12 host_rdata", host_rdata, 16'h0000);
        cmp("R12 core_rdata", core_rdata, 16'h0000);
        cycle(0,0,3'd0,16'h0, 1,0,0,3'd7,16'h0);
        cmp("R12 status hi", core_rdata, 16'h0080);
        cycle(0,0,3'd0,16'h0, 1,0,0,3'd6,16'h0);
        cmp("R12 status lo", core_rdata, 16'h0000);
        cycle(0,0,3'd0,16'h0, 1,0,1,3'd0,16'h0);
        cmp("R12 enable word", core_rdata, 16'h0000);

        // table walk
        for (int i = 0; i < NSTEP; i++) begin
            host_rd = TBL[i].hrd; host_wr = TBL[i].hwr; host_narrow = TBL[i].hnar;
            host_idx = TBL[i].hidx; host_wdata = TBL[i].hwd;
            core_rd = TBL[i].crd; core_wr = TBL[i].cwr; core_mask_sel = TBL[i].cmsk;
            core_idx = TBL[i].cidx; core_wdata = TBL[i].cwd;
            @(negedge clk);
            idle();
            if (TBL[i].chkh)
                cmp($sformatf("R%0d step %0d host_rdata", TBL[i].req, i), host_rdata, TBL[i].exph);
            if (TBL[i].chkc)
                cmp($sformatf("R%0d step %0d core_rdata", TBL[i].req, i), core_rdata, TBL[i].expc);
            cmp($sformatf("R%0d step %0d irq", TBL[i].req, i),
                {14'd0, irq_host_rd, irq_host_wr}, {14'd0, TBL[i].irq});
        end

        // R8 soft reset from the core, with strobes during the pulse
        cycle(0,1,3'd5,16'h5A5A, 0,0,0,3'd0,16'h0);
        cycle(0,0,3'd0,16'h0, 0,1,1,3'd0,16'h0020);
        cmp("R6 hw5 enabled irq", {14'd0, irq_host_rd, irq_host_wr}, 16'h0001);
        cycle(0,0,3'd0,16'h0, 0,1,0,3'd7,16'h0040);
        hi_cnt = 0;
        for (int k = 0; k < 8; k++) begin
            if (soft_rst) hi_cnt++;
            if (k == 0) begin
                host_wr = 1; host_idx = 3'd5; host_wdata = 16'h9999;
                core_wr = 1; core_mask_sel = 1; core_wdata = 16'hFFFF;
            end
            @(negedge clk);
            idle();
        end
        cmp("R8 pulse length", 16'(hi_cnt), 16'd5);
        cmp("R8 irq after pulse", {14'd0, irq_host_rd, irq_host_wr}, 16'h0000);
        cycle(0,0,3'd0,16'h0, 1,0,1,3'd0,16'h0);
        cmp("R8 enable word cleared", core_rdata, 16'h0000);
        cycle(0,0,3'd0,16'h0, 1,0,0,3'd6,16'h0);
        cmp("R8 status lo cleared", core_rdata, 16'h0000);
        cycle(0,0,3'd0,16'h0, 1,0,0,3'd7,16'h0);
        cmp("R8 status hi reset", core_rdata, 16'h0080);
        cycle(0,0,3'd0,16'h0, 1,0,0,3'd5,16'h0);
        cmp("R8 data kept, pulse write ignored", core_rdata, 16'h5A5A);

        // R8 soft reset from the host side
        cycle(0,1,3'd7,16'h00C0, 0,0,0,3'd0,16'h0);
        cmp("R8 host fire", {15'd0, soft_rst}, 16'h0001);
        repeat (6) @(negedge clk);
        cmp("R8 host pulse ended", {15'd0, soft_rst}, 16'h0000);

        // R8 data survives a hardware reset; R12 state restored
        cycle(0,1,3'd0,16'h7777, 0,1,1,3'd0,16'h3F3F);
        cycle(1,0,3'd0,16'h0, 0,0,0,3'd0,16'h0);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        cmp("R12 host_rdata after reset", host_rdata, 16'h0000);
        cmp("R12 irq after reset", {14'd0, irq_host_rd, irq_host_wr}, 16'h0000);
        cycle(0,0,3'd0,16'h0, 1,0,0,3'd0,16'h0);
        cmp("R8 data kept over hardware reset", core_rdata, 16'h7777);
        cycle(0,0,3'd0,16'h0, 1,0,1,3'd0,16'h0);
        cmp("R12 enable word after reset", core_rdata, 16'h0000);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule